// File: doc/BRIEF.md
# Second Operand Shifter

This block forms the second operand of a 32-bit integer ALU, together with the carry bit that the shifting step produces. A 12-bit operand field from the instruction word selects one of two forms. In the immediate form, an 8-bit constant is rotated right by twice a 4-bit count, which reaches many 32-bit constants without a literal pool. In the register form, a source register value goes through one of four shift kinds. The shift amount comes either from a 5-bit count inside the field or from the low byte of a second register.

The caller presents the mode select, the field, both register values and the current carry flag. When the clock enable is high at a rising edge, the operand and carry-out are captured in an output register. The ALU uses them in the next cycle. The output register holds its value while the enable is low.

Top module: `shop_operand_unit`

## Requirements
- R1: With `imm_mode`=1, `op_out` is the zero-extended `field[7:0]` rotated right by 2×`field[11:8]` positions. For example, field 0x4FF gives 0xFF000000.
- R2: With `imm_mode`=1, `c_out` equals `c_in` when `field[11:8]` is 0, and equals bit 31 of the rotated result otherwise.
- R3: With `imm_mode`=0, `field[6:5]` selects the shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR. `field[4]`=0 takes the amount from `field[11:7]`. `field[4]`=1 takes it from `rs_val[7:0]`. `field[3:0]`, `rs_val[31:8]` and, when `field[4]`=1, `field[7]` have no effect.
- R4: A field-count LSL by n passes `rm_val` and `c_in` when n is 0. Otherwise it gives `rm_val` shifted left by n, with carry `rm_val[32-n]`.
- R5: A field-count LSR or ASR treats a count of 0 as 32. At 32, LSR gives 0 and ASR gives 32 copies of `rm_val[31]`, and both carry out `rm_val[31]`. For n from 1 to 31, the carry is `rm_val[n-1]`.
- R6: A field-count ROR of 0 rotates one place through carry: the result is {`c_in`, `rm_val[31:1]`} and the carry is `rm_val[0]`. A nonzero count rotates right with carry equal to bit 31 of the result.
- R7: A register-supplied amount of 0 passes `rm_val` and `c_in` unchanged for every shift kind.
- R8: A register-supplied LSL or LSR of exactly 32 gives 0, with carry `rm_val[0]` for LSL and `rm_val[31]` for LSR. An amount above 32 gives 0 with carry 0.
- R9: A register-supplied ASR of 32 or more gives 32 copies of `rm_val[31]` and carries out `rm_val[31]`.
- R10: A register-supplied ROR uses the amount modulo 32. A nonzero multiple of 32 returns `rm_val` with carry `rm_val[31]`. Any other amount carries out bit 31 of the result.
- R11: While `rst_n` is low, both outputs are 0. The outputs change only at a rising clock edge where `en` is 1, and then show the result for the inputs sampled at that edge. While `en` is 0 they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output register |
| imm_mode | input | 1 | 1 = rotated 8-bit constant, 0 = shifted register |
| field | input | 12 | Operand field from the instruction |
| rm_val | input | 32 | Register value to be shifted |
| rs_val | input | 32 | Register whose low byte supplies the shift amount |
| c_in | input | 1 | Current carry flag |
| op_out | output | 32 | Second ALU operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the places where a count of 0 or 32 changes meaning:
- An LSR or ASR that does not map a field count of 0 to 32 passes the value through instead of clearing or sign-filling it.
- A rotate that does not turn a zero count into a rotate through carry loses `c_in` from bit 31.
- For register-supplied amounts, the bench crosses 32 in both directions and uses nonzero multiples of 32 for ROR. A design that compares only the low five bits, or that truncates the amount before saturating it, then returns the unshifted value or the wrong carry.
- In the immediate form, rotate counts of 0 and 4 (field 0x4FF) expose a missing doubling and a carry taken from bit 31 when it should come from `c_in`.

// File: rtl/shop_pkg.sv
package shop_pkg;

  localparam int SHOP_W  = 32;
  localparam int SHOP_AW = $clog2(SHOP_W) + 1;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

  // Control word handed from the amount decoder to the shift network.
  typedef struct packed {
    shift_kind_e              kind;
    logic [SHOP_AW-1:0]       amt;       // 0..SHOP_W
    logic                     kill;      // result 0, carry 0
    logic                     rrx;       // one-place rotate through carry
    logic                     msb_carry; // rotate carry from result MSB
    logic                     use_const; // operand is the 8-bit constant
  } shift_ctl_t;

endpackage

// File: rtl/shop_amt_decode.sv
module shop_amt_decode
  import shop_pkg::*;
#(
  parameter int W  = SHOP_W,
  parameter int AW = SHOP_AW
) (
  input  logic        imm_mode,
  input  logic [11:0] field,
  input  logic [7:0]  rs_amt,
  output shift_ctl_t  ctl
);

  localparam logic [AW-1:0] FULL = AW'(W);
  localparam logic [7:0]    FULL8 = 8'(W);

  logic [4:0] cnt5;
  assign cnt5 = field[11:7];

  always_comb begin
    ctl           = '0;
    ctl.kind      = shift_kind_e'(field[6:5]);
    if (imm_mode) begin
      ctl.kind      = SHK_ROR;
      ctl.amt       = AW'({field[11:8], 1'b0});
      ctl.msb_carry = (field[11:8] != 4'd0);
      ctl.use_const = 1'b1;
    end else if (field[4]) begin
      if (rs_amt != 8'd0) begin
        unique case (ctl.kind)
          SHK_LSL, SHK_LSR: begin
            if (rs_amt > FULL8) ctl.kill = 1'b1;
            else                ctl.amt  = rs_amt[AW-1:0];
          end
          SHK_ASR: ctl.amt = (rs_amt >= FULL8) ? FULL : rs_amt[AW-1:0];
          default: begin
            ctl.amt       = AW'(rs_amt[AW-2:0]);
            ctl.msb_carry = 1'b1;
          end
        endcase
      end
    end else begin
      unique case (ctl.kind)
        SHK_LSL:          ctl.amt = AW'(cnt5);
        SHK_LSR, SHK_ASR: ctl.amt = (cnt5 == 5'd0) ? FULL : AW'(cnt5);
        default: begin
          if (cnt5 == 5'd0) begin
            ctl.rrx = 1'b1;
          end else begin
            ctl.amt       = AW'(cnt5);
            ctl.msb_carry = 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int W  = SHOP_W,
  parameter int AW = SHOP_AW
) (
  input  logic [W-1:0]  val,
  input  logic          cin,
  input  shift_kind_e   kind,
  input  logic [AW-1:0] amt,
  input  logic          msb_carry,
  output logic [W-1:0]  res,
  output logic          cout
);

  localparam int RSTG = AW - 1;  // rotate stages: amounts 0..W-1

  logic [W:0]   lx [AW+1];
  logic [W:0]   rx [AW+1];
  logic [W-1:0] rt [RSTG+1];
  logic         fill;

  assign fill  = (kind == SHK_ASR) ? val[W-1] : 1'b0;
  assign lx[0] = {cin, val};
  assign rx[0] = {val, cin};
  assign rt[0] = val;

  // Left and right networks carry one extra bit that ends up as carry.
  for (genvar s = 0; s < AW; s++) begin : g_shift
    localparam int SH = 2 ** s;
    logic [W:0] fmask;
    assign fmask     = fill ? ~({(W+1){1'b1}} >> SH) : '0;
    assign lx[s+1]   = amt[s] ? (lx[s] << SH) : lx[s];
    assign rx[s+1]   = amt[s] ? ((rx[s] >> SH) | fmask) : rx[s];
  end

  for (genvar s = 0; s < RSTG; s++) begin : g_rot
    localparam int SH = 2 ** s;
    assign rt[s+1] = amt[s] ? {rt[s][SH-1:0], rt[s][W-1:SH]} : rt[s];
  end

  always_comb begin
    unique case (kind)
      SHK_LSL: begin
        res  = lx[AW][W-1:0];
        cout = lx[AW][W];
      end
      SHK_LSR, SHK_ASR: begin
        res  = rx[AW][W:1];
        cout = rx[AW][0];
      end
      default: begin
        res  = rt[RSTG];
        cout = msb_carry ? rt[RSTG][W-1] : cin;
      end
    endcase
  end

endmodule

// File: rtl/shop_operand_unit.sv
module shop_operand_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = SHOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              imm_mode,
  input  logic [11:0]       field,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              c_in,
  output logic [DATA_W-1:0] op_out,
  output logic              c_out
);

  localparam int AW = $clog2(DATA_W) + 1;

  shift_ctl_t        ctl;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] core_res;
  logic              core_c;
  logic [DATA_W-1:0] op_nxt;
  logic              c_nxt;
  logic [DATA_W-1:0] op_q;
  logic              c_q;

  shop_amt_decode #(.W(DATA_W), .AW(AW)) u_dec (
    .imm_mode (imm_mode),
    .field    (field),
    .rs_amt   (rs_val[7:0]),
    .ctl      (ctl)
  );

  assign src = ctl.use_const ? DATA_W'(field[7:0]) : rm_val;

  shop_barrel #(.W(DATA_W), .AW(AW)) u_bar (
    .val       (src),
    .cin       (c_in),
    .kind      (ctl.kind),
    .amt       (ctl.amt),
    .msb_carry (ctl.msb_carry),
    .res       (core_res),
    .cout      (core_c)
  );

  // Next-state selection
  always_comb begin
    if (ctl.kill) begin
      op_nxt = '0;
      c_nxt  = 1'b0;
    end else if (ctl.rrx) begin
      op_nxt = {c_in, rm_val[DATA_W-1:1]};
      c_nxt  = rm_val[0];
    end else begin
      op_nxt = core_res;
      c_nxt  = core_c;
    end
  end

  // Output register with written-out clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      c_q  <= 1'b0;
    end else if (en) begin
      op_q <= op_nxt;
      c_q  <= c_nxt;
    end
  end

  assign op_out = op_q;
  assign c_out  = c_q;

  AST_IMM_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && imm_mode) |=> ($countones(op_out) == $past($countones(field[7:0])))); // R1

  AST_IMM_ROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && imm_mode && field[11:8] == 4'd0) |=>
      (op_out == DATA_W'($past(field[7:0])) && c_out == $past(c_in))); // R2

  AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !imm_mode && field[4] && rs_val[7:0] == 8'd0) |=>
      (op_out == $past(rm_val) && c_out == $past(c_in))); // R7

  AST_REG_LOGIC_BIG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !imm_mode && field[4] && !field[6] && rs_val[7:0] > 8'd32) |=>
      (op_out == '0 && !c_out)); // R8

  AST_REG_ASR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !imm_mode && field[4] && field[6:5] == 2'b10 && rs_val[7:0] >= 8'd32) |=>
      (op_out == {DATA_W{$past(rm_val[DATA_W-1])}} && c_out == $past(rm_val[DATA_W-1]))); // R9

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(op_out) && $stable(c_out))); // R11

endmodule

// File: tb/shop_operand_unit_tb.sv
`timescale 1ns/1ps
module shop_operand_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic        imm_mode;
  logic [11:0] field;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        c_in;
  logic [31:0] op_out;
  logic        c_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  shop_operand_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .imm_mode(imm_mode), .field(field),
    .rm_val(rm_val), .rs_val(rs_val), .c_in(c_in), .op_out(op_out), .c_out(c_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model written from the requirements: returns {carry, value}
  function automatic logic [32:0] model(logic im, logic [11:0] f, logic [31:0] rm,
                                        logic [31:0] rs, logic c);
    logic [31:0] v;
    logic [63:0] wide;
    logic [1:0]  typ;
    int          n;
    int          m;
    if (im) begin
      n = 2 * int'(f[11:8]);
      v = ({24'h0, f[7:0]} >> n) | ({24'h0, f[7:0]} << (32 - n));
      return {(n == 0) ? c : v[31], v};
    end
    typ = f[6:5];
    if (!f[4]) begin
      n = int'(f[11:7]);
      if (n == 0) begin
        if (typ == 2'b00) return {c, rm};
        if (typ == 2'b11) return {rm[0], c, rm[31:1]};
        n = 32;
      end
    end else begin
      n = int'(rs[7:0]);
      if (n == 0) return {c, rm};
    end
    case (typ)
      2'b00: begin wide = {32'h0, rm} << n; return {wide[32], wide[31:0]}; end
      2'b01: begin wide = {rm, 32'h0} >> n; return {wide[31], wide[63:32]}; end
      2'b10: begin
        if (n >= 32) return {rm[31], {32{rm[31]}}};
        v = $signed(rm) >>> n;
        return {rm[n-1], v};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {rm[31], rm};
        v = (rm >> m) | (rm << (32 - m));
        return {v[31], v};
      end
    endcase
  endfunction

  function automatic logic [11:0] fcnt(logic [4:0] a, logic [1:0] t);
    return {a, t, 1'b0, 4'h0};
  endfunction

  function automatic logic [11:0] freg(logic [1:0] t);
    return {4'h0, 1'b0, t, 1'b1, 4'h0};
  endfunction

  task automatic check(string tag, logic [31:0] eo, logic ec);
    n_chk++;
    if (op_out !== eo || c_out !== ec) begin
      n_bad++;
      $display("FAIL %s: op=%h c=%b expected op=%h c=%b", tag, op_out, c_out, eo, ec);
    end
  endtask

  task automatic apply(logic im, logic [11:0] f, logic [31:0] rm, logic [31:0] rs, logic c);
    @(negedge clk);
    imm_mode = im; field = f; rm_val = rm; rs_val = rs; c_in = c; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run(string tag, logic im, logic [11:0] f, logic [31:0] rm,
                     logic [31:0] rs, logic c);
    logic [32:0] e;
    e = model(im, f, rm, rs, c);
    apply(im, f, rm, rs, c);
    check(tag, e[31:0], e[32]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; imm_mode = 1'b0; field = '0;
    rm_val = '0; rs_val = '0; c_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset", 32'h0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_imm();
    apply(1'b1, 12'h4FF, 32'h0, 32'h0, 1'b0);
    check("R1 imm 0x4FF", 32'hFF00_0000, 1'b1);
    apply(1'b1, 12'h0A5, 32'h0, 32'h0, 1'b1);
    check("R2 imm rot0 carry", 32'h0000_00A5, 1'b1);
    apply(1'b1, 12'h17F, 32'h0, 32'h0, 1'b1);
    check("R2 imm rot2 carry", 32'hC000_001F, 1'b1);
    for (int r = 0; r < 16; r++) run("R1 imm sweep", 1'b1, {r[3:0], 8'h81}, 32'h0, 32'h0, r[0]);
  endtask

  task automatic t_cnt_shifts();
    run("R4 lsl 0", 1'b0, fcnt(5'd0, 2'b00), 32'hDEAD_BEEF, 32'h0, 1'b1);
    apply(1'b0, fcnt(5'd4, 2'b00), 32'hF000_0001, 32'h0, 1'b0);
    check("R4 lsl 4", 32'h0000_0010, 1'b1);
    apply(1'b0, fcnt(5'd0, 2'b01), 32'h8000_0000, 32'h0, 1'b0);
    check("R5 lsr 0 as 32", 32'h0, 1'b1);
    apply(1'b0, fcnt(5'd0, 2'b10), 32'h8000_0000, 32'h0, 1'b0);
    check("R5 asr 0 as 32", 32'hFFFF_FFFF, 1'b1);
    run("R5 lsr 3", 1'b0, fcnt(5'd3, 2'b01), 32'h1234_5674, 32'h0, 1'b0);
    run("R5 asr 31", 1'b0, fcnt(5'd31, 2'b10), 32'h8000_0000, 32'h0, 1'b0);
    apply(1'b0, fcnt(5'd0, 2'b11), 32'h0000_0003, 32'h0, 1'b1);
    check("R6 rrx", 32'h8000_0001, 1'b1);
    apply(1'b0, fcnt(5'd8, 2'b11), 32'h1234_5680, 32'h0, 1'b0);
    check("R6 ror 8", 32'h8012_3456, 1'b1);
  endtask

  task automatic t_reg_amounts();
    for (int t = 0; t < 4; t++) begin
      run("R7 reg amt 0", 1'b0, freg(t[1:0]), 32'h8765_4321, 32'hFFFF_FF00, 1'b1);
      run("R7 reg amt 0 c0", 1'b0, freg(t[1:0]), 32'h8765_4321, 32'h0000_0000, 1'b0);
    end
    apply(1'b0, freg(2'b00), 32'h0000_0001, 32'd32, 1'b0);
    check("R8 lsl 32", 32'h0, 1'b1);
    apply(1'b0, freg(2'b01), 32'h8000_0000, 32'd32, 1'b0);
    check("R8 lsr 32", 32'h0, 1'b1);
    apply(1'b0, freg(2'b00), 32'hFFFF_FFFF, 32'd33, 1'b1);
    check("R8 lsl 33", 32'h0, 1'b0);
    apply(1'b0, freg(2'b01), 32'hFFFF_FFFF, 32'd200, 1'b1);
    check("R8 lsr 200", 32'h0, 1'b0);
    run("R8 lsl 31", 1'b0, freg(2'b00), 32'h0000_0003, 32'd31, 1'b0);
    apply(1'b0, freg(2'b10), 32'h8000_0000, 32'd32, 1'b0);
    check("R9 asr 32", 32'hFFFF_FFFF, 1'b1);
    apply(1'b0, freg(2'b10), 32'h7FFF_FFFF, 32'd255, 1'b1);
    check("R9 asr 255", 32'h0, 1'b0);
    apply(1'b0, freg(2'b11), 32'h8000_0001, 32'd64, 1'b0);
    check("R10 ror 64", 32'h8000_0001, 1'b1);
    apply(1'b0, freg(2'b11), 32'h0000_0001, 32'd33, 1'b0);
    check("R10 ror 33", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_ignored();
    // R3: bits 3:0, bit 7 (register amount) and rs_val[31:8] have no effect
    apply(1'b0, {4'h0, 1'b1, 2'b00, 1'b1, 4'hA}, 32'h0000_00F0, 32'hABCD_EF04, 1'b0);
    check("R3 ignored bits", 32'h0000_0F00, 1'b0);
    apply(1'b0, fcnt(5'd1, 2'b01) | 12'h00F, 32'h0000_0003, 32'hFFFF_FFFF, 1'b0);
    check("R3 low bits ignored", 32'h0000_0001, 1'b1);
  endtask

  task automatic t_sweep();
    logic [31:0] lf;
    lf = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run("R3 sweep", lf[20], lf[11:0], {lf[15:0], lf[31:16]} ^ 32'h5A5A_A5A5,
          {24'h0, (lf[5] ? 8'(lf[29:24]) : lf[31:24])}, lf[13]);
    end
  endtask

  task automatic t_hold();
    logic [32:0] e;
    e = model(1'b0, fcnt(5'd5, 2'b00), 32'h0000_0101, 32'h0, 1'b0);
    apply(1'b0, fcnt(5'd5, 2'b00), 32'h0000_0101, 32'h0, 1'b0);
    @(negedge clk);
    en = 1'b0; imm_mode = 1'b1; field = 12'hFFF; rm_val = 32'hFFFF_FFFF; c_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 hold", e[31:0], e[32]);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check("R11 update", 32'h0000_03FC, 1'b0);
  endtask

  initial begin
    t_reset();
    t_imm();
    t_cnt_shifts();
    t_reg_amounts();
    t_ignored();
    t_hold();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: run did not complete, got hang expected finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule